// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritization

This block collects every interrupt condition of a 16550-style serial port and reduces them to a single 4-bit identification code. That code names the most urgent cause still pending. A host that services the port reads the code, handles the named cause with the matching register access, and reads the code again until bit 0 is set. The serial shifters, the FIFOs, the baud generator and the character-timeout counter sit outside the block. They report their state through status inputs and register-access strobes.

Line errors, a loaded receive character and a character timeout arrive as single-cycle event pulses, and each is held in a sticky flag. The flag stays set until the register access that services it. FIFO fill level and transmitter-empty arrive as levels and are used directly. The four modem lines are edge-detected into sticky change flags. A small two-state machine handles the transmit-empty interrupt. It starts in `TXM_OPEN`. It takes the transition *read-while-empty* to `TXM_MASKED` when the identification code is read while the transmitter is empty. It takes the transition *holding-write* back to `TXM_OPEN` on any transmit holding write. A transmit-empty interrupt is only reported in `TXM_OPEN`.

A four-bit enable vector gates each source before prioritization. The request line is high whenever the gated code shows a pending cause.

Top module: `uart_intr_id`

## Requirements
- R1: With no enabled cause pending, including directly after reset, `iid` is 4'b0001 and `irq` is low.
- R2: Any nonzero `line_err` pulse sets a line-status cause, reported as 4'b0110 from the next cycle. Only `rd_lsr` clears it, and only in a cycle with no new `line_err`, because a new error wins over a read.
- R3: With `fifo_en` low, an `rx_load` pulse gives 4'b0100 from the next cycle until the cycle after an `rd_rbr` that has no simultaneous `rx_load`. With `fifo_en` high, 4'b0100 follows `rx_at_trig` in the same cycle.
- R4: With `fifo_en` high, an `rx_timeout` pulse gives 4'b1100 from the next cycle until the cycle after an `rd_rbr`. With `fifo_en` low, the timeout cause is held cleared and `rx_timeout` has no effect.
- R5: While `tx_empty` is high and the state machine is in `TXM_OPEN`, a transmit-empty cause is reported as 4'b0010 in the same cycle.
- R6: `rd_iir` with `tx_empty` high moves the machine to `TXM_MASKED` from the next cycle. `wr_thr` returns it to `TXM_OPEN`, and a write wins over a simultaneous read.
- R7: Modem inputs use the bit positions 0 CTS, 1 DSR, 2 DCD, 3 RI. A change of bits 0 to 2, or a 1-to-0 change of bit 3, sets a sticky flag, and any flag gives 4'b0000 from the cycle after the change is sampled. A 0-to-1 change of bit 3 sets nothing. Changes in the first clock after reset are not detected.
- R8: `rd_msr` clears all four modem flags. A change sampled in the same cycle sets its flag anyway.
- R9: `ier` bit 0 enables line status, bit 1 receive data and timeout, bit 2 transmit empty, and bit 3 modem. A disabled cause never appears in `iid`. `irq` is high exactly when `iid` bit 0 is low.
- R10: When several enabled causes pend, the order is line status, then receive data, then timeout, then transmit empty, then modem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Receive FIFO mode enable |
| ier | input | 4 | Per-source enables (R9 bit map) |
| line_err | input | 4 | Overrun, parity, framing and break event pulses |
| rx_load | input | 1 | Character landed in receive buffer (non-FIFO) |
| rx_at_trig | input | 1 | Receive FIFO count beyond trigger level |
| rx_timeout | input | 1 | Character timeout event pulse |
| tx_empty | input | 1 | Transmit holding register or FIFO empty |
| mdm_in | input | 4 | Modem lines: CTS, DSR, DCD, RI |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_rbr | input | 1 | Receive buffer or FIFO read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| wr_thr | input | 1 | Transmit holding register or FIFO write strobe |
| iid | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
Results fall due at two latencies. Level inputs (`rx_at_trig` in FIFO mode, `tx_empty`, `ier`) change `iid` within the same cycle. Event pulses, register strobes and modem changes act through one register, so their effect shows only after the next rising edge. The bench drives every input just after a falling edge. Its behavioural model advances on the rising edge, and `iid` and `irq` are compared on each following falling edge, so both latencies are checked at the cycle where they are due. Directed sequences cover the simultaneous set-and-clear cases and the priority order, and a seeded random phase follows.

// File: rtl/uart_intr_pkg.sv
package uart_intr_pkg;

    typedef enum logic [3:0] {
        IID_NONE  = 4'b0001,
        IID_LINE  = 4'b0110,
        IID_RDATA = 4'b0100,
        IID_TOUT  = 4'b1100,
        IID_TXEMP = 4'b0010,
        IID_MDM   = 4'b0000
    } iid_code_t;

    typedef enum logic {
        TXM_OPEN   = 1'b0,
        TXM_MASKED = 1'b1
    } txm_state_t;

    localparam int EN_LINE  = 0;
    localparam int EN_RX    = 1;
    localparam int EN_TX    = 2;
    localparam int EN_MDM   = 3;
    localparam int EN_W     = 4;

endpackage

// File: rtl/uart_intr_txm.sv
module uart_intr_txm
    import uart_intr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic rd_iir,
    input  logic wr_thr,
    output logic thr_pend
);

    txm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXM_OPEN:   if (rd_iir && tx_empty && !wr_thr) state_d = TXM_MASKED;
            TXM_MASKED: if (wr_thr)                        state_d = TXM_OPEN;
            default:                                       state_d = TXM_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXM_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        thr_pend = 1'b0;
        unique case (state_q)
            TXM_OPEN:   thr_pend = tx_empty;
            TXM_MASKED: thr_pend = 1'b0;
            default:    thr_pend = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_intr_mdm.sv
module uart_intr_mdm #(
    parameter int W      = 4,
    parameter int RI_IDX = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mdm_in,
    input  logic         rd_msr,
    output logic [W-1:0] delta
);

    logic [W-1:0] prev_q;
    logic         primed_q;
    logic [W-1:0] edge_hit;

    for (genvar i = 0; i < W; i++) begin : g_edge
        if (i == RI_IDX) begin : g_trail
            assign edge_hit[i] = primed_q & prev_q[i] & ~mdm_in[i];
        end else begin : g_any
            assign edge_hit[i] = primed_q & (prev_q[i] ^ mdm_in[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
            delta    <= '0;
        end else begin
            prev_q   <= mdm_in;
            primed_q <= 1'b1;
            delta    <= (rd_msr ? '0 : delta) | edge_hit;
        end
    end

endmodule

// File: rtl/uart_intr_flags.sv
module uart_intr_flags #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [ERR_W-1:0] line_err,
    input  logic             rx_load,
    input  logic             rx_timeout,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    output logic             line_pend,
    output logic             rxbuf_full,
    output logic             tout_pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_pend  <= 1'b0;
            rxbuf_full <= 1'b0;
            tout_pend  <= 1'b0;
        end else begin
            line_pend  <= (line_pend & ~rd_lsr) | (|line_err);
            rxbuf_full <= rx_load | (rxbuf_full & ~rd_rbr);
            tout_pend  <= fifo_en & (rx_timeout | (tout_pend & ~rd_rbr));
        end
    end

endmodule

// File: rtl/uart_intr_prio.sv
module uart_intr_prio
    import uart_intr_pkg::*;
(
    input  logic      p_line,
    input  logic      p_rdata,
    input  logic      p_tout,
    input  logic      p_txemp,
    input  logic      p_mdm,
    output iid_code_t code
);

    always_comb begin
        if (p_line)       code = IID_LINE;
        else if (p_rdata) code = IID_RDATA;
        else if (p_tout)  code = IID_TOUT;
        else if (p_txemp) code = IID_TXEMP;
        else if (p_mdm)   code = IID_MDM;
        else              code = IID_NONE;
    end

endmodule

// File: rtl/uart_intr_id.sv
module uart_intr_id
    import uart_intr_pkg::*;
#(
    parameter int ERR_W  = 4,
    parameter int MDM_W  = 4,
    parameter int RI_IDX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [EN_W-1:0]  ier,
    input  logic [ERR_W-1:0] line_err,
    input  logic             rx_load,
    input  logic             rx_at_trig,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic [MDM_W-1:0] mdm_in,
    input  logic             rd_iir,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             rd_msr,
    input  logic             wr_thr,
    output logic [3:0]       iid,
    output logic             irq
);

    logic line_pend, rxbuf_full, tout_pend, thr_pend;
    logic [MDM_W-1:0] delta;
    logic rdata_pend;
    iid_code_t code;

    uart_intr_flags #(.ERR_W(ERR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .line_err(line_err),
        .rx_load(rx_load), .rx_timeout(rx_timeout), .rd_lsr(rd_lsr),
        .rd_rbr(rd_rbr), .line_pend(line_pend), .rxbuf_full(rxbuf_full),
        .tout_pend(tout_pend)
    );

    uart_intr_txm u_txm (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .rd_iir(rd_iir),
        .wr_thr(wr_thr), .thr_pend(thr_pend)
    );

    uart_intr_mdm #(.W(MDM_W), .RI_IDX(RI_IDX)) u_mdm (
        .clk(clk), .rst_n(rst_n), .mdm_in(mdm_in), .rd_msr(rd_msr),
        .delta(delta)
    );

    assign rdata_pend = fifo_en ? rx_at_trig : rxbuf_full;

    uart_intr_prio u_prio (
        .p_line (ier[EN_LINE] & line_pend),
        .p_rdata(ier[EN_RX]   & rdata_pend),
        .p_tout (ier[EN_RX]   & tout_pend),
        .p_txemp(ier[EN_TX]   & thr_pend),
        .p_mdm  (ier[EN_MDM]  & (|delta)),
        .code   (code)
    );

    assign iid = code;
    assign irq = ~code[0];

endmodule

// File: rtl/uart_intr_id_chk.sv
module uart_intr_id_chk #(
    parameter int ERR_W = 4,
    parameter int MDM_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic [3:0]       ier,
    input logic [ERR_W-1:0] line_err,
    input logic             rx_at_trig,
    input logic             tx_empty,
    input logic [MDM_W-1:0] mdm_in,
    input logic             rd_iir,
    input logic             rd_lsr,
    input logic             rd_msr,
    input logic             wr_thr,
    input logic [3:0]       iid,
    input logic             irq
);

    a_r2_err_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_err) |=> (iid == 4'b0110 || !ier[0]));

    a_r2_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (iid == 4'b0110 && !rd_lsr) |=> (iid == 4'b0110 || !ier[0]));

    a_r3_fifo_level: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_at_trig && ier[1] && iid != 4'b0110) |-> iid == 4'b0100);

    a_r6_iir_masks_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && tx_empty && !wr_thr && iid == 4'b0010) |=> iid != 4'b0010);

    a_r8_msr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iid == 4'b0000 && rd_msr && $stable(mdm_in)) |=> iid != 4'b0000);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'b0000) |-> !irq);

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq != iid[0]);

endmodule

bind uart_intr_id uart_intr_id_chk #(.ERR_W(ERR_W), .MDM_W(MDM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier), .line_err(line_err),
    .rx_at_trig(rx_at_trig), .tx_empty(tx_empty), .mdm_in(mdm_in),
    .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .iid(iid), .irq(irq)
);

// File: tb/uart_intr_id_test.sv
module uart_intr_id_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [3:0] ier = 4'h0;
    logic [3:0] line_err = 4'h0;
    logic       rx_load = 1'b0, rx_at_trig = 1'b0, rx_timeout = 1'b0;
    logic       tx_empty = 1'b0;
    logic [3:0] mdm_in = 4'h0;
    logic       rd_iir = 1'b0, rd_lsr = 1'b0, rd_rbr = 1'b0, rd_msr = 1'b0;
    logic       wr_thr = 1'b0;
    logic [3:0] iid;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_intr_id uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier),
        .line_err(line_err), .rx_load(rx_load), .rx_at_trig(rx_at_trig),
        .rx_timeout(rx_timeout), .tx_empty(tx_empty), .mdm_in(mdm_in),
        .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr),
        .wr_thr(wr_thr), .iid(iid), .irq(irq)
    );

    // behavioural reference model
    bit m_line, m_rx, m_tout, m_masked, m_primed;
    bit [3:0] m_flag, m_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_line = 0; m_rx = 0; m_tout = 0; m_masked = 0;
            m_primed = 0; m_flag = 0; m_prev = 0;
        end else begin
            if (line_err != 0)  m_line = 1;
            else if (rd_lsr)    m_line = 0;
            if (rx_load)        m_rx = 1;
            else if (rd_rbr)    m_rx = 0;
            if (!fifo_en)       m_tout = 0;
            else if (rx_timeout) m_tout = 1;
            else if (rd_rbr)    m_tout = 0;
            if (wr_thr)         m_masked = 0;
            else if (rd_iir && tx_empty) m_masked = 1;
            if (rd_msr) m_flag = 0;
            if (m_primed) begin
                for (int b = 0; b < 3; b++)
                    if (mdm_in[b] != m_prev[b]) m_flag[b] = 1;
                if (m_prev[3] == 1 && mdm_in[3] == 0) m_flag[3] = 1;
            end
            m_prev = mdm_in;
            m_primed = 1;
        end
    end

    function automatic logic [3:0] expect_iid();
        bit rdata;
        rdata = fifo_en ? rx_at_trig : m_rx;
        if (ier[0] && m_line)                 return 4'b0110;
        if (ier[1] && rdata)                  return 4'b0100;
        if (ier[1] && m_tout)                 return 4'b1100;
        if (ier[2] && tx_empty && !m_masked)  return 4'b0010;
        if (ier[3] && m_flag != 0)            return 4'b0000;
        return 4'b0001;
    endfunction

    function automatic string tag_of(logic [3:0] c);
        case (c)
            4'b0110: return "R2/R10";
            4'b0100: return "R3/R10";
            4'b1100: return "R4/R10";
            4'b0010: return "R5/R6";
            4'b0000: return "R7/R8";
            default: return "R1/R9";
        endcase
    endfunction

    task automatic compare(string ctx);
        logic [3:0] e;
        e = expect_iid();
        checks++;
        if (iid !== e) begin
            errors++;
            $display("FAIL %s (%s): iid actual %b expected %b", tag_of(e), ctx, iid, e);
        end
        checks++;
        if (irq !== (e != 4'b0001)) begin
            errors++;
            $display("FAIL R9 (%s): irq actual %b expected %b", ctx, irq, e != 4'b0001);
        end
    endtask

    task automatic clr_strobes();
        line_err = 0; rx_load = 0; rx_timeout = 0;
        rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
    endtask

    task automatic cyc(string ctx);
        @(posedge clk);
        @(negedge clk);
        compare(ctx);
        clr_strobes();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1;
        cyc("R1 after reset");
        ier = 4'hF;
        cyc("R1 enabled, idle");

        // R2 line status
        line_err = 4'b0100; cyc("R2 error pulse");
        cyc("R2 held"); cyc("R2 held");
        rd_lsr = 1; line_err = 4'b0001; cyc("R2 error wins over read");
        rd_lsr = 1; cyc("R2 read clears");

        // R3 non-FIFO receive
        rx_load = 1; cyc("R3 load");
        rd_rbr = 1; rx_load = 1; cyc("R3 load wins over read");
        rd_rbr = 1; cyc("R3 read clears");
        rx_timeout = 1; cyc("R4 timeout ignored non-FIFO");

        // R3/R4 FIFO mode
        fifo_en = 1; rx_at_trig = 1; cyc("R3 level same cycle");
        rx_timeout = 1; cyc("R10 data over timeout");
        rx_at_trig = 0; cyc("R4 timeout shown");
        rd_rbr = 1; cyc("R4 read clears timeout");
        rx_timeout = 1; cyc("R4 timeout again");
        fifo_en = 0; cyc("R4 cleared leaving FIFO mode");

        // R10 all at once, then service in order
        line_err = 4'b1000; rx_load = 1; tx_empty = 1; mdm_in[0] = 1;
        cyc("R10 all pending");
        rd_lsr = 1; cyc("R10 next is data");
        rd_rbr = 1; cyc("R10 next is tx empty");
        rd_iir = 1; wr_thr = 1; cyc("R6 write wins over read");
        rd_iir = 1; cyc("R6 read masks");
        cyc("R6 stays masked");
        rd_msr = 1; cyc("R8 msr clears");
        wr_thr = 1; cyc("R6 write unmasks");
        rd_iir = 1; cyc("R6 mask again");
        tx_empty = 0; wr_thr = 1; cyc("R5 not empty");

        // R7/R8 modem details
        mdm_in[3] = 1; cyc("R7 RI rise ignored");
        cyc("R7 RI rise ignored");
        mdm_in[3] = 0; cyc("R7 RI trailing edge");
        rd_msr = 1; mdm_in[2] = 1; cyc("R8 edge wins over read");
        rd_msr = 1; cyc("R8 read clears");
        mdm_in[1] = 1; cyc("R7 DSR change");

        // R9 gating
        line_err = 4'b0010; tx_empty = 1; ier = 4'h0; cyc("R9 all disabled");
        ier = 4'b1000; cyc("R9 modem only");
        ier = 4'b0100; cyc("R9 tx only");
        ier = 4'hF; cyc("R9 re-enabled");
        rd_lsr = 1; rd_msr = 1; cyc("cleanup");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            line_err   = (r[3:0] == 0) ? r[7:4] : 4'h0;
            rx_load    = (r[6:4] == 0);
            rx_timeout = (r[9:7] == 0);
            rd_iir     = (r[11:10] == 0);
            rd_lsr     = (r[14:12] == 0);
            rd_rbr     = (r[17:15] == 0);
            rd_msr     = (r[20:18] == 0);
            wr_thr     = (r[23:21] == 0);
            if (r[27:24] == 0) mdm_in = $urandom;
            if (r[29:28] == 0) tx_empty = ~tx_empty;
            if (r[31:30] == 0) rx_at_trig = ~rx_at_trig;
            if (n % 97 == 0)   fifo_en = ~fifo_en;
            if (n % 211 == 0)  ier = $urandom;
            cyc("random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule